// File: doc/BRIEF.md
# Pipeline Redirect and Squash Controller

This block steers the fetch address and the bubble insertion of a five-stage in-order pipeline whenever control flow changes. Each cycle it reads the opcode class of the instruction in decode and of the one in execute, the zero flag of the execute-stage operand and the hazard stall request. From these it produces three selects: one for the next program counter, one for the input of the decode instruction register and one for the input of the execute instruction register. A bubble is an all-zero no-op word that the datapath inserts when a select asks for it.

Unconditional jumps are resolved in decode. A jump costs one squashed fetch. Conditional branches are resolved in execute. A taken branch costs two squashed instructions. When both happen in one cycle, the older instruction (the branch in execute) wins. A hazard stall freezes the program counter and the decode register and sends a bubble into execute. A taken branch overrides a stall, because the stalled decode instruction is on the wrong path anyway.

A two-state machine, FLUSH and RUN, covers start-up. Reset forces FLUSH, and FLUSH moves to RUN on the first clock edge after reset is released. RUN stays in RUN until the next reset. In FLUSH the pipeline registers are filled with bubbles and fetch advances sequentially.

Top module: `pctl_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle between its release and the next rising clock edge (state FLUSH), the outputs are `pc_sel`=0 (sequential), `dir_sel`=1 (bubble) and `eir_sel`=1 (bubble), whatever the other inputs are.
- R2: In RUN, with no taken branch and no stall, a decode opcode of 1 (jump) or 2 (jump and link) gives `pc_sel`=1 (absolute target), `dir_sel`=1 and `eir_sel`=0 (pass the decode instruction).
- R3: In RUN, with no taken branch and no stall, a decode opcode of 3 (register jump) or 4 (register jump and link) gives `pc_sel`=2 (register-indirect target), `dir_sel`=1 and `eir_sel`=0.
- R4: In RUN, an execute opcode of 5 (branch if zero) with `exe_zero`=1, or 6 (branch if nonzero) with `exe_zero`=0, is a taken branch: `pc_sel`=3 (branch target), `dir_sel`=1, `eir_sel`=1.
- R5: A branch opcode in execute whose condition fails has no effect: the outputs are those that the decode opcode and `stall` alone select.
- R6: A taken branch in execute overrides a jump in decode and an asserted `stall`: the outputs are those of R4.
- R7: In RUN, with `stall`=1 and no taken branch, the outputs are `pc_sel`=4 (hold), `dir_sel`=2 (hold) and `eir_sel`=1, even when decode holds a jump.
- R8: In RUN, when no redirect, stall or taken branch applies (opcode 0, "other", in both stages), the outputs are `pc_sel`=0, `dir_sel`=0 (load from instruction memory) and `eir_sel`=0.
- R9: Jump opcodes in execute and branch opcodes in decode cause no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opc_dec | input | 3 | Opcode class of the instruction in decode |
| opc_exe | input | 3 | Opcode class of the instruction in execute |
| exe_zero | input | 1 | Execute-stage operand equals zero |
| stall | input | 1 | Data-hazard stall request |
| pc_sel | output | 3 | Next-PC select: 0 seq, 1 abs, 2 indirect, 3 branch, 4 hold |
| dir_sel | output | 2 | Decode IR input: 0 fetch, 1 bubble, 2 hold |
| eir_sel | output | 1 | Execute IR input: 0 decode instruction, 1 bubble |

## Verification
A jump can sit in decode while a branch sits in execute, and a stall can coincide with either of them. These collisions are the heart of the priority logic. The vector table places such pairs in the same cycle, for example a jump in decode together with a taken branch, a stall together with a taken branch, and a stall together with a jump behind a branch that fails. Each collision is judged by whether the outputs equal those of the older winner. Failed branches paired with jumps confirm that the decode decision is restored when the execute condition fails.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int OPC_W  = 3;
    localparam int PCS_W  = 3;
    localparam int DSEL_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_OTHER         = 3'd0,
        OPC_JUMP          = 3'd1,
        OPC_JUMP_LINK     = 3'd2,
        OPC_JUMP_REG      = 3'd3,
        OPC_JUMP_REG_LINK = 3'd4,
        OPC_BR_ZERO       = 3'd5,
        OPC_BR_NONZERO    = 3'd6,
        OPC_SPARE         = 3'd7
    } opc_t;

    typedef enum logic [PCS_W-1:0] {
        PCS_SEQ  = 3'd0,
        PCS_ABS  = 3'd1,
        PCS_IND  = 3'd2,
        PCS_BR   = 3'd3,
        PCS_HOLD = 3'd4
    } pc_sel_t;

    typedef enum logic [DSEL_W-1:0] {
        DS_FETCH  = 2'd0,
        DS_BUBBLE = 2'd1,
        DS_KEEP   = 2'd2
    } dsel_t;

    typedef enum logic {
        ES_PASS   = 1'b0,
        ES_BUBBLE = 1'b1
    } esel_t;

    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } ctl_state_t;

    typedef enum logic [2:0] {
        KIND_FLUSH,
        KIND_BRANCH,
        KIND_STALL,
        KIND_ABS,
        KIND_IND,
        KIND_SEQ
    } kind_t;

endpackage

// File: rtl/pctl_classify.sv
module pctl_classify
    import pctl_pkg::*;
(
    input  logic [OPC_W-1:0] opc_dec,
    input  logic [OPC_W-1:0] opc_exe,
    input  logic             exe_zero,
    output logic             jump_abs,
    output logic             jump_ind,
    output logic             br_taken
);

    always_comb begin
        jump_abs = 1'b0;
        jump_ind = 1'b0;
        unique case (opc_t'(opc_dec))
            OPC_JUMP, OPC_JUMP_LINK:         jump_abs = 1'b1;
            OPC_JUMP_REG, OPC_JUMP_REG_LINK: jump_ind = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        br_taken = 1'b0;
        unique case (opc_t'(opc_exe))
            OPC_BR_ZERO:    br_taken = exe_zero;
            OPC_BR_NONZERO: br_taken = !exe_zero;
            default: ;
        endcase
    end

endmodule

// File: rtl/pctl_arbiter.sv
module pctl_arbiter
    import pctl_pkg::*;
(
    input  logic    run,
    input  logic    br_taken,
    input  logic    stall,
    input  logic    jump_abs,
    input  logic    jump_ind,
    output pc_sel_t pc_sel,
    output dsel_t   dir_sel,
    output esel_t   eir_sel
);

    kind_t kind;

    // Older instruction first: branch in execute, then stall, then decode jump.
    always_comb begin
        if (!run)          kind = KIND_FLUSH;
        else if (br_taken) kind = KIND_BRANCH;
        else if (stall)    kind = KIND_STALL;
        else if (jump_abs) kind = KIND_ABS;
        else if (jump_ind) kind = KIND_IND;
        else               kind = KIND_SEQ;
    end

    always_comb begin
        unique case (kind)
            KIND_FLUSH: begin
                pc_sel = PCS_SEQ;  dir_sel = DS_BUBBLE; eir_sel = ES_BUBBLE;
            end
            KIND_BRANCH: begin
                pc_sel = PCS_BR;   dir_sel = DS_BUBBLE; eir_sel = ES_BUBBLE;
            end
            KIND_STALL: begin
                pc_sel = PCS_HOLD; dir_sel = DS_KEEP;   eir_sel = ES_BUBBLE;
            end
            KIND_ABS: begin
                pc_sel = PCS_ABS;  dir_sel = DS_BUBBLE; eir_sel = ES_PASS;
            end
            KIND_IND: begin
                pc_sel = PCS_IND;  dir_sel = DS_BUBBLE; eir_sel = ES_PASS;
            end
            default: begin
                pc_sel = PCS_SEQ;  dir_sel = DS_FETCH;  eir_sel = ES_PASS;
            end
        endcase
    end

endmodule

// File: rtl/pctl_top.sv
module pctl_top
    import pctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opc_dec,
    input  logic [OPC_W-1:0]  opc_exe,
    input  logic              exe_zero,
    input  logic              stall,
    output logic [PCS_W-1:0]  pc_sel,
    output logic [DSEL_W-1:0] dir_sel,
    output logic              eir_sel
);

    ctl_state_t state, state_nxt;
    logic       run;
    logic       jump_abs, jump_ind, br_taken;
    pc_sel_t    pc_sel_e;
    dsel_t      dir_sel_e;
    esel_t      eir_sel_e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLUSH;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_FLUSH: begin state_nxt = ST_RUN; run = 1'b0; end
            ST_RUN:   begin state_nxt = ST_RUN; run = 1'b1; end
            default:  begin state_nxt = ST_FLUSH; run = 1'b0; end
        endcase
    end

    pctl_classify u_cls (
        .opc_dec  (opc_dec),
        .opc_exe  (opc_exe),
        .exe_zero (exe_zero),
        .jump_abs (jump_abs),
        .jump_ind (jump_ind),
        .br_taken (br_taken)
    );

    pctl_arbiter u_arb (
        .run      (run),
        .br_taken (br_taken),
        .stall    (stall),
        .jump_abs (jump_abs),
        .jump_ind (jump_ind),
        .pc_sel   (pc_sel_e),
        .dir_sel  (dir_sel_e),
        .eir_sel  (eir_sel_e)
    );

    assign pc_sel  = pc_sel_e;
    assign dir_sel = dir_sel_e;
    assign eir_sel = eir_sel_e;

endmodule

// File: rtl/pctl_chk.sv
module pctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [2:0] opc_dec,
    input logic [2:0] opc_exe,
    input logic       exe_zero,
    input logic       stall,
    input logic [2:0] pc_sel,
    input logic [1:0] dir_sel,
    input logic       eir_sel
);

    logic taken_c, abs_c, ind_c;
    assign taken_c = (opc_exe == 3'd5 && exe_zero) || (opc_exe == 3'd6 && !exe_zero);
    assign abs_c   = (opc_dec == 3'd1) || (opc_dec == 3'd2);
    assign ind_c   = (opc_dec == 3'd3) || (opc_dec == 3'd4);

    // R1
    flush_bubbles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pc_sel == 3'd0 && dir_sel == 2'd1 && eir_sel));

    // R4
    taken_kills_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && taken_c) |-> (pc_sel == 3'd3 && dir_sel == 2'd1 && eir_sel));

    // R7
    stall_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !taken_c && stall) |-> (pc_sel == 3'd4 && dir_sel == 2'd2 && eir_sel));

    // R2
    abs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !taken_c && !stall && abs_c) |-> (pc_sel == 3'd1 && dir_sel == 2'd1 && !eir_sel));

    // R3
    ind_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !taken_c && !stall && ind_c) |-> (pc_sel == 3'd2 && dir_sel == 2'd1 && !eir_sel));

    // R8
    sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !taken_c && !stall && !abs_c && !ind_c) |-> (pc_sel == 3'd0 && dir_sel == 2'd0 && !eir_sel));

endmodule

bind pctl_top pctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .opc_dec  (opc_dec),
    .opc_exe  (opc_exe),
    .exe_zero (exe_zero),
    .stall    (stall),
    .pc_sel   (pc_sel),
    .dir_sel  (dir_sel),
    .eir_sel  (eir_sel)
);

// File: tb/sim_pctl_top.sv
module sim_pctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] opc_dec = 3'd0;
    logic [2:0] opc_exe = 3'd0;
    logic       exe_zero = 1'b0;
    logic       stall = 1'b0;
    logic [2:0] pc_sel;
    logic [1:0] dir_sel;
    logic       eir_sel;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    pctl_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .opc_dec  (opc_dec),
        .opc_exe  (opc_exe),
        .exe_zero (exe_zero),
        .stall    (stall),
        .pc_sel   (pc_sel),
        .dir_sel  (dir_sel),
        .eir_sel  (eir_sel)
    );

    // {req, opc_dec, opc_exe, zero, stall, exp pc_sel, exp dir_sel, exp eir_sel}
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {4'd8, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R8 plain flow
        {4'd2, 3'd1, 3'd0, 1'b0, 1'b0, 3'd1, 2'd1, 1'b0}, // R2 jump
        {4'd2, 3'd2, 3'd0, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0}, // R2 jump and link
        {4'd3, 3'd3, 3'd0, 1'b0, 1'b0, 3'd2, 2'd1, 1'b0}, // R3 register jump
        {4'd3, 3'd4, 3'd0, 1'b0, 1'b0, 3'd2, 2'd1, 1'b0}, // R3 register jump and link
        {4'd4, 3'd0, 3'd5, 1'b1, 1'b0, 3'd3, 2'd1, 1'b1}, // R4 branch-if-zero taken
        {4'd4, 3'd0, 3'd6, 1'b0, 1'b0, 3'd3, 2'd1, 1'b1}, // R4 branch-if-nonzero taken
        {4'd5, 3'd0, 3'd5, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R5 fails
        {4'd5, 3'd0, 3'd6, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0}, // R5 fails
        {4'd6, 3'd1, 3'd5, 1'b1, 1'b0, 3'd3, 2'd1, 1'b1}, // R6 branch beats jump
        {4'd6, 3'd3, 3'd6, 1'b0, 1'b1, 3'd3, 2'd1, 1'b1}, // R6 branch beats stall and jump
        {4'd7, 3'd0, 3'd0, 1'b0, 1'b1, 3'd4, 2'd2, 1'b1}, // R7 stall
        {4'd7, 3'd2, 3'd0, 1'b0, 1'b1, 3'd4, 2'd2, 1'b1}, // R7 stall beats jump
        {4'd7, 3'd3, 3'd5, 1'b0, 1'b1, 3'd4, 2'd2, 1'b1}, // R7 stall behind failed branch
        {4'd9, 3'd5, 3'd1, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 swapped stages
        {4'd9, 3'd6, 3'd4, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 swapped stages
        {4'd5, 3'd1, 3'd6, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0}  // R5 failed branch, jump decides
    };

    task automatic check(input int req, input logic [2:0] ep, input logic [1:0] ed, input logic ee);
        n_vec++;
        if (pc_sel !== ep || dir_sel !== ed || eir_sel !== ee) begin
            n_bad++;
            $display("FAIL R%0d: got pc=%0d dir=%0d eir=%0d expected pc=%0d dir=%0d eir=%0d",
                     req, pc_sel, dir_sel, eir_sel, ep, ed, ee);
        end
    endtask

    task automatic drive(input logic [2:0] d, input logic [2:0] e, input logic z, input logic s);
        @(negedge clk);
        opc_dec = d; opc_exe = e; exe_zero = z; stall = s;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R1: in reset, with a taken branch and a jump presented
        drive(3'd1, 3'd5, 1'b1, 1'b0);
        check(1, 3'd0, 2'd1, 1'b1);
        drive(3'd0, 3'd0, 1'b0, 1'b1);
        check(1, 3'd0, 2'd1, 1'b1);
        // R1: released, still in FLUSH until the next rising edge
        @(negedge clk);
        rst_n = 1'b1;
        opc_dec = 3'd3; opc_exe = 3'd6; exe_zero = 1'b0; stall = 1'b0;
        #2;
        check(1, 3'd0, 2'd1, 1'b1);
        // after that edge: RUN, taken branch seen (R4)
        drive(3'd3, 3'd6, 1'b0, 1'b0);
        check(4, 3'd3, 2'd1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][13:11], VEC[i][10:8], VEC[i][7], VEC[i][6]);
            check(int'(VEC[i][17:14]), VEC[i][5:3], VEC[i][2:1], VEC[i][0]);
        end

        // R1: reset reasserted mid-run returns to bubbles at once
        drive(3'd1, 3'd0, 1'b0, 1'b0);
        check(2, 3'd1, 2'd1, 1'b0);
        rst_n = 1'b0;
        #1;
        check(1, 3'd0, 2'd1, 1'b1);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        #1;
        check(1, 3'd0, 2'd1, 1'b1);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        check(8, 3'd0, 2'd0, 1'b0);

        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule